// File: doc/BRIEF.md
# Serial Flash Sector Write-Protect Controller

This block decides whether a program or erase aimed at one sector of a serial flash array may go ahead. It combines three conditions. The first is a software write-enable latch, which is set and cleared by command strobes. The second is an active-low hardware protect pin. The third is a protected sector range held in a 16-bit configuration register. The range is a contiguous run of sector groups. It is anchored either at sector 0 or at the last sector, and a direction bit picks which end.

The command decoder in front of the block delivers single-cycle strobes: write enable, write disable, configuration write, configuration read and write request. A write request carries a sector address. One cycle after each write request, the block answers with exactly one pulse: either `writeAllowed` or `writeRejected`. The block also drives the read-clock-edge select and the hold/ready-busy pin mode from the configuration register, for use by the output logic elsewhere in the device.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset, the configuration low byte reads 8'h09, `writeEnabled` is 0, `readEdgeRise` is 0, `holdPinMode` is 2'b01, and neither answer pulse is active.
- R2: The configuration low byte decodes as follows. Bits 7:4 are the range code. Bit 3 is the anchor direction. Bit 2 drives `readEdgeRise`, where 1 means read data is driven on the rising clock edge and 0 means the falling edge. Bits 1:0 drive `holdPinMode`.
- R3: Bits 15:8 of the configuration register are stored as 0 whatever the write data holds, and they read back as 0.
- R4: `wrenCmd` sets the write-enable latch and `wrdiCmd` clears it. If both arrive in the same cycle, the latch is cleared.
- R5: A configuration write takes effect only when the latch is set and `wpN` is high. Otherwise the register keeps its value.
- R6: An accepted program/erase or an accepted configuration write clears the latch at the same clock edge. A rejected request leaves the latch unchanged.
- R7: Each `writeReq` is answered one cycle later by exactly one of `writeAllowed` and `writeRejected`, and each pulse lasts one cycle. The request is allowed only when three things hold: the latch is set, `wpN` is high, and the sector lies outside the protected range. Without a request, neither pulse is active.
- R8: The range code sets the protected size. Code 0 protects nothing. Codes 1 to 8 protect 2^(code-1) groups of 2^GROUP_SHIFT sectors each; if that exceeds the array, the whole array is protected. Codes 9 to 15 protect the whole array.
- R9: With the direction bit at 0, the protected run starts at sector 0 and extends upward. With the direction bit at 1, it ends at the last sector.
- R10: While `wpN` is low, every program/erase request is rejected and every configuration write is ignored, whatever the range setting.
- R11: A `cfgRdCmd` strobe raises `cfgRdValid` for one cycle, one cycle later, with the full register value on `cfgRdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wpN | input | 1 | Hardware protect pin, active low |
| wrenCmd | input | 1 | Write-enable command strobe |
| wrdiCmd | input | 1 | Write-disable command strobe |
| cfgWrCmd | input | 1 | Configuration write strobe |
| cfgWrData | input | CFG_W | Configuration write data |
| cfgRdCmd | input | 1 | Configuration read strobe |
| writeReq | input | 1 | Program/erase request strobe |
| writeSector | input | SECTOR_AW | Target sector of the request |
| writeAllowed | output | 1 | One-cycle grant pulse |
| writeRejected | output | 1 | One-cycle reject pulse |
| writeEnabled | output | 1 | Write-enable latch state |
| cfgRdValid | output | 1 | Read data valid pulse |
| cfgRdData | output | CFG_W | Configuration register readback |
| readEdgeRise | output | 1 | Read data clock edge select |
| holdPinMode | output | 2 | Hold/ready-busy pin function |

## Verification
The bench builds the block with SECTOR_AW=9 and GROUP_SHIFT=1, which gives 512 sectors in 256 groups of two. At this size, range code 8 covers exactly half the array, and codes 1 to 8 each protect a different size. For every range code in both directions, the bench sends a request to every sector. This covers each boundary sector on both sides of every run, and it also covers the full-array codes. Latch, protect-pin and reserved-bit cases are checked as directed sequences before the sweep.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  // Low configuration byte; field order follows the register bit positions.
  typedef struct packed {
    logic [3:0] rangeCode;
    logic       rangeFromTop;
    logic       readEdgeRise;
    logic [1:0] holdMode;
  } cfgFields_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic cfgLoad;
    logic rdCapture;
  } dpStrobe_t;

  localparam logic [7:0] CFG_RESET = 8'h09;
  localparam int MAX_SIZED_CODE = 8;
endpackage

// File: rtl/fwp_datapath.sv
module fwp_datapath
  import fwp_pkg::*;
#(
  parameter int SECTOR_AW   = 14,
  parameter int GROUP_SHIFT = 6,
  parameter int CFG_W       = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strb,
  input  logic [CFG_W-1:0]     cfgWrData,
  input  logic [SECTOR_AW-1:0] sector,
  output logic                 inRange,
  output cfgFields_t           cfgNow,
  output logic                 rdValid,
  output logic [CFG_W-1:0]     rdData
);
  localparam int GROUP_AW = SECTOR_AW - GROUP_SHIFT;
  localparam logic [SECTOR_AW:0] TOTAL = (SECTOR_AW+1)'(1) << SECTOR_AW;

  cfgFields_t cfgReg;
  logic [SECTOR_AW:0] protCount;
  logic [SECTOR_AW:0] sectorExt;
  logic [4:0]         codeIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgReg <= cfgFields_t'(CFG_RESET);
    else if (strb.cfgLoad) cfgReg <= cfgFields_t'(cfgWrData[7:0]);
  end

  assign codeIdx = {1'b0, cfgReg.rangeCode} - 5'd1;

  // Number of protected sectors, saturated to the array size.
  always_comb begin
    if (cfgReg.rangeCode == 4'd0)
      protCount = '0;
    else if (int'(cfgReg.rangeCode) > MAX_SIZED_CODE || int'(codeIdx) >= GROUP_AW)
      protCount = TOTAL;
    else
      protCount = (SECTOR_AW+1)'(1) << (int'(codeIdx) + GROUP_SHIFT);
  end

  assign sectorExt = {1'b0, sector};
  assign inRange   = cfgReg.rangeFromTop ? (sectorExt >= (TOTAL - protCount))
                                         : (sectorExt < protCount);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.rdCapture;
      if (strb.rdCapture) rdData <= {{(CFG_W-8){1'b0}}, cfgReg};
    end
  end

  assign cfgNow = cfgReg;
endmodule

// File: rtl/fwp_control.sv
module fwp_control
  import fwp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wpN,
  input  logic      wrenCmd,
  input  logic      wrdiCmd,
  input  logic      cfgWrCmd,
  input  logic      cfgRdCmd,
  input  logic      writeReq,
  input  logic      inRange,
  output dpStrobe_t strb,
  output logic      wel,
  output logic      allowed,
  output logic      rejected
);
  logic writeGrant;
  logic cfgGrant;

  assign writeGrant = writeReq & wel & wpN & ~inRange;
  assign cfgGrant   = cfgWrCmd & wel & wpN;

  assign strb.cfgLoad   = cfgGrant;
  assign strb.rdCapture = cfgRdCmd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel      <= 1'b0;
      allowed  <= 1'b0;
      rejected <= 1'b0;
    end else begin
      if (writeGrant || cfgGrant || wrdiCmd) wel <= 1'b0;
      else if (wrenCmd)                      wel <= 1'b1;
      allowed  <= writeGrant;
      rejected <= writeReq & ~writeGrant;
    end
  end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import fwp_pkg::*;
#(
  parameter int SECTOR_AW   = 14,
  parameter int GROUP_SHIFT = 6,
  parameter int CFG_W       = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wpN,
  input  logic                 wrenCmd,
  input  logic                 wrdiCmd,
  input  logic                 cfgWrCmd,
  input  logic [CFG_W-1:0]     cfgWrData,
  input  logic                 cfgRdCmd,
  input  logic                 writeReq,
  input  logic [SECTOR_AW-1:0] writeSector,
  output logic                 writeAllowed,
  output logic                 writeRejected,
  output logic                 writeEnabled,
  output logic                 cfgRdValid,
  output logic [CFG_W-1:0]     cfgRdData,
  output logic                 readEdgeRise,
  output logic [1:0]           holdPinMode
);
  dpStrobe_t  strb;
  cfgFields_t cfgNow;
  logic       inRange;

  fwp_control u_ctrl (
    .clk(clk), .rstN(rstN), .wpN(wpN), .wrenCmd(wrenCmd), .wrdiCmd(wrdiCmd),
    .cfgWrCmd(cfgWrCmd), .cfgRdCmd(cfgRdCmd), .writeReq(writeReq),
    .inRange(inRange), .strb(strb), .wel(writeEnabled),
    .allowed(writeAllowed), .rejected(writeRejected)
  );

  fwp_datapath #(.SECTOR_AW(SECTOR_AW), .GROUP_SHIFT(GROUP_SHIFT), .CFG_W(CFG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWrData(cfgWrData),
    .sector(writeSector), .inRange(inRange), .cfgNow(cfgNow),
    .rdValid(cfgRdValid), .rdData(cfgRdData)
  );

  assign readEdgeRise = cfgNow.readEdgeRise;
  assign holdPinMode  = cfgNow.holdMode;
endmodule

// File: rtl/fwp_checker.sv
module fwp_checker #(
  parameter int CFG_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wpN,
  input logic             cfgWrCmd,
  input logic             cfgRdCmd,
  input logic             writeReq,
  input logic             writeAllowed,
  input logic             writeRejected,
  input logic             writeEnabled,
  input logic             cfgRdValid,
  input logic [CFG_W-1:0] cfgRdData,
  input logic             readEdgeRise,
  input logic [1:0]       holdPinMode
);
  p_one_answer_r7: assert property (@(posedge clk) disable iff (!rstN)
    writeReq |=> (writeAllowed ^ writeRejected));

  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rstN)
    !writeReq |=> (!writeAllowed && !writeRejected));

  p_grant_needs_latch_r7: assert property (@(posedge clk) disable iff (!rstN)
    writeReq && !writeEnabled |=> !writeAllowed);

  p_grant_clears_latch_r6: assert property (@(posedge clk) disable iff (!rstN)
    writeAllowed |-> !writeEnabled);

  p_pin_blocks_r10: assert property (@(posedge clk) disable iff (!rstN)
    writeReq && !wpN |=> writeRejected);

  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrCmd |=> ($stable(readEdgeRise) && $stable(holdPinMode)));

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdValid |-> (cfgRdData[CFG_W-1:8] == '0));

  p_read_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdCmd |=> cfgRdValid);
endmodule

bind flash_wp_ctrl fwp_checker #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rstN(rstN), .wpN(wpN), .cfgWrCmd(cfgWrCmd), .cfgRdCmd(cfgRdCmd),
  .writeReq(writeReq), .writeAllowed(writeAllowed), .writeRejected(writeRejected),
  .writeEnabled(writeEnabled), .cfgRdValid(cfgRdValid), .cfgRdData(cfgRdData),
  .readEdgeRise(readEdgeRise), .holdPinMode(holdPinMode)
);

// File: tb/sim_flash_wp_ctrl.sv
`timescale 1ns/1ps
module sim_flash_wp_ctrl;
  localparam int SAW = 9;
  localparam int GS  = 1;
  localparam int CW  = 16;
  localparam int TOTAL = 1 << SAW;
  localparam int NGROUPS = 1 << (SAW - GS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wpN = 1'b1, wrenCmd = 1'b0, wrdiCmd = 1'b0, cfgWrCmd = 1'b0, cfgRdCmd = 1'b0;
  logic writeReq = 1'b0;
  logic [CW-1:0] cfgWrData = '0;
  logic [SAW-1:0] writeSector = '0;
  logic writeAllowed, writeRejected, writeEnabled, cfgRdValid, readEdgeRise;
  logic [CW-1:0] cfgRdData;
  logic [1:0] holdPinMode;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_wp_ctrl #(.SECTOR_AW(SAW), .GROUP_SHIFT(GS), .CFG_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .wpN(wpN), .wrenCmd(wrenCmd), .wrdiCmd(wrdiCmd),
    .cfgWrCmd(cfgWrCmd), .cfgWrData(cfgWrData), .cfgRdCmd(cfgRdCmd),
    .writeReq(writeReq), .writeSector(writeSector), .writeAllowed(writeAllowed),
    .writeRejected(writeRejected), .writeEnabled(writeEnabled),
    .cfgRdValid(cfgRdValid), .cfgRdData(cfgRdData),
    .readEdgeRise(readEdgeRise), .holdPinMode(holdPinMode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expProt(input int code, input bit top, input int sec);
    int groups;
    int cnt;
    if (code == 0) groups = 0;
    else if (code > 8) groups = NGROUPS;
    else groups = ((1 << (code - 1)) > NGROUPS) ? NGROUPS : (1 << (code - 1));
    cnt = groups << GS;
    return top ? (sec >= TOTAL - cnt) : (sec < cnt);
  endfunction

  task automatic doWren;
    @(negedge clk) wrenCmd = 1'b1;
    @(negedge clk) wrenCmd = 1'b0;
  endtask

  task automatic doWrdi;
    @(negedge clk) wrdiCmd = 1'b1;
    @(negedge clk) wrdiCmd = 1'b0;
  endtask

  task automatic doCfgWrite(input logic [CW-1:0] d);
    @(negedge clk) begin cfgWrCmd = 1'b1; cfgWrData = d; end
    @(negedge clk) cfgWrCmd = 1'b0;
  endtask

  task automatic doCfgRead(output logic [CW-1:0] d, output logic v);
    @(negedge clk) cfgRdCmd = 1'b1;
    @(negedge clk) begin cfgRdCmd = 1'b0; v = cfgRdValid; d = cfgRdData; end
  endtask

  task automatic doWrite(input int sec, output logic a, output logic r);
    @(negedge clk) begin writeReq = 1'b1; writeSector = SAW'(sec); end
    @(negedge clk) begin writeReq = 1'b0; a = writeAllowed; r = writeRejected; end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000 && !done) begin
        done = 1'b1;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [CW-1:0] rd;
    logic v, a, r;
    logic [7:0] lowByte;
    bit exp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(writeEnabled == 1'b0, "R1 wel", writeEnabled, 0);
    check(readEdgeRise == 1'b0, "R1 rce", readEdgeRise, 0);
    check(holdPinMode == 2'b01, "R1 hold", holdPinMode, 1);
    check(!writeAllowed && !writeRejected, "R1 idle", {writeAllowed, writeRejected}, 0);
    doCfgRead(rd, v);
    check(v && rd == 16'h0009, "R1 R11 cfg", rd, 16'h0009);

    // R7 request without latch is rejected
    doWrite(3, a, r);
    check(!a && r, "R7 no latch", {a, r}, 1);
    // R5 config write without latch ignored
    doCfgWrite(16'h00F4);
    doCfgRead(rd, v);
    check(rd == 16'h0009, "R5 no latch", rd, 16'h0009);

    // R4 latch set/clear and clear priority
    doWren;
    check(writeEnabled == 1'b1, "R4 set", writeEnabled, 1);
    doWrdi;
    check(writeEnabled == 1'b0, "R4 clear", writeEnabled, 0);
    doWren;
    @(negedge clk) begin wrenCmd = 1'b1; wrdiCmd = 1'b1; end
    @(negedge clk) begin wrenCmd = 1'b0; wrdiCmd = 1'b0; end
    check(writeEnabled == 1'b0, "R4 both", writeEnabled, 0);

    // R10 protect pin low
    doWren;
    wpN = 1'b0;
    doCfgWrite(16'h00F4);
    doCfgRead(rd, v);
    check(rd == 16'h0009, "R10 R5 cfg ignored", rd, 16'h0009);
    check(writeEnabled == 1'b1, "R6 rejected keeps latch", writeEnabled, 1);
    doWrite(5, a, r);
    check(!a && r, "R10 write", {a, r}, 1);
    check(writeEnabled == 1'b1, "R6 keep", writeEnabled, 1);
    wpN = 1'b1;
    doWrite(5, a, r);
    check(a && !r, "R7 grant", {a, r}, 2);
    check(writeEnabled == 1'b0, "R6 clear on grant", writeEnabled, 0);

    // R8/R9 sweep over every code, direction and sector
    for (int top = 0; top < 2; top++) begin
      for (int code = 0; code < 16; code++) begin
        lowByte = {4'(code), 1'(top), code[0], code[2:1]};
        doWren;
        doCfgWrite({8'hFF, lowByte});
        check(writeEnabled == 1'b0, "R6 cfg clears", writeEnabled, 0);
        doCfgRead(rd, v);
        check(v && rd == {8'h00, lowByte}, "R2 R3 readback", rd, {8'h00, lowByte});
        check(readEdgeRise == code[0], "R2 rce", readEdgeRise, code[0]);
        check(holdPinMode == code[2:1], "R2 hold", holdPinMode, code[2:1]);
        for (int s = 0; s < TOTAL; s++) begin
          exp = !expProt(code, top[0], s);
          doWren;
          doWrite(s, a, r);
          if (top == 0) check(a == exp && r == !exp, "R8 R9 low anchor", {a, r}, {exp, !exp});
          else          check(a == exp && r == !exp, "R8 R9 high anchor", {a, r}, {exp, !exp});
          check(writeEnabled == !exp, "R6 latch after", writeEnabled, !exp);
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule